// File: doc/BRIEF.md
# Pad Input Event Detector

This block turns the receive level of one general-purpose pad into interrupt events. The raw level is first synchronised to the core clock. It then passes a receive gate and an optional polarity flip. An optional debounce filter follows, counting a slow real-time tick. The last stage is a trigger detector, set by a two-bit mode, that decides when an event occurs.

Each event sets a sticky status bit, which software clears with a one-cycle write-one-to-clear pulse. The same event is also sent to every interrupt destination whose route-enable bit is set. There are four destinations, and any mix of them may be enabled at once. Configuration arrives as plain input fields, which are assumed to come from a register block elsewhere.

Top module: `pad_event_detect`

## Requirements
- R1: After reset, `status_o` is 0 and all bits of `route_o` are 0.
- R2: With `trig_mode_i` = 0 (level), a change on the pad reaches `status_o` and `route_o` on the third rising clock edge after it is sampled. Each enabled route bit then stays high for as long as the conditioned level is 1.
- R3: With `trig_mode_i` = 1 (single edge) and `rx_invert_i` = 0, a rising edge of the raw pad level raises an event. A falling edge does not.
- R4: With `trig_mode_i` = 1 and `rx_invert_i` = 1, a falling edge of the raw pad level raises an event. A rising edge does not.
- R5: With `trig_mode_i` = 3 (both edges), either edge of the conditioned level raises an event.
- R6: With `trig_mode_i` = 2 (off), no input activity sets `status_o` or drives any `route_o` bit.
- R7: `rx_invert_i` = 1 flips the received level ahead of both level and edge detection. In level mode, a low pad therefore gives an active-high request.
- R8: For each event, `route_o[k]` is driven only if `route_en_i[k]` is 1, and several bits may be high together. Bit 0 is NMI, bit 1 is SMI, bit 2 is SCI and bit 3 is IOAPIC. With `route_en_i` = 0, the status bit is still set.
- R9: `status_o` stays 1 until a cycle with `status_clr_i` = 1 and no new event. If an event and a clear fall in the same cycle, the event wins.
- R10: While `rx_disable_i` = 1, the conditioned level is held at 0, and no event sets `status_o` or drives `route_o`.
- R11: With `deb_en_i` = 1 and a `deb_code_i` of 3 to 15, a new level is accepted only once it has held for 2^code ticks of `rtc_tick_i`. A shorter excursion is dropped.
- R12: A change of `deb_code_i` or `deb_en_i` restarts the debounce count and keeps the level accepted so far.
- R13: A `deb_code_i` below 3 behaves as if debounce were disabled.
- R14: In the edge modes, each `route_o` pulse lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_rx_i | input | 1 | Raw pad receive level (asynchronous) |
| rtc_tick_i | input | 1 | One-cycle pulse at the real-time tick rate |
| rx_disable_i | input | 1 | Forces the conditioned level inactive |
| rx_invert_i | input | 1 | Inverts the received level |
| trig_mode_i | input | 2 | 0 level, 1 single edge, 2 off, 3 both edges |
| route_en_i | input | 4 | Destination enables: [0] NMI, [1] SMI, [2] SCI, [3] IOAPIC |
| deb_en_i | input | 1 | Debounce enable |
| deb_code_i | input | 4 | Debounce length exponent (2^code ticks) |
| status_clr_i | input | 1 | Write-one-to-clear pulse for the status bit |
| status_o | output | 1 | Sticky event status |
| route_o | output | 4 | Per-destination interrupt request |

## Verification
The hardest case to reach is a debounce count that is cut short by a configuration change. A design that keeps counting would accept the level early. A design that also drops the accepted level would fire too early or not at all. To reach it, the bench drives a pending level for five ticks and then changes the exponent from 3 to 4. It then shows that twelve further ticks (seventeen in total) are not enough, and that the sixteenth tick after the change is. A glitch shorter than the window is also run in both-edge mode, to show that a returning level restarts the count.

// File: rtl/pad_evt_pkg.sv
package pad_evt_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'd0,
        TRIG_SINGLE = 2'd1,
        TRIG_OFF    = 2'd2,
        TRIG_BOTH   = 2'd3
    } trig_mode_e;

    localparam int unsigned DEST_COUNT = 4;

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (STAGES > 1) begin
            state_d.chain = {state_q.chain[STAGES-2:0], async_i};
        end else begin
            state_d.chain[0] = async_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sync_o = state_q.chain[STAGES-1];
endmodule

// File: rtl/pad_debounce.sv
module pad_debounce #(
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned MIN_CODE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_i,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              lvl_o
);
    localparam int unsigned CNT_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic              acc;
        logic [CNT_W-1:0]  cnt;
        logic              cfg_en;
        logic [CODE_W-1:0] cfg_code;
    } deb_state_t;

    deb_state_t state_d, state_q;
    logic       eff_en;
    logic [CNT_W:0] limit;

    always_comb begin
        eff_en  = en_i && (code_i >= CODE_W'(MIN_CODE));
        limit   = ({{CNT_W{1'b0}}, 1'b1} << code_i) - 1'b1;
        state_d = state_q;
        state_d.cfg_en   = eff_en;
        state_d.cfg_code = code_i;
        if (!eff_en) begin
            state_d.acc = lvl_i;
            state_d.cnt = '0;
        end else if (eff_en != state_q.cfg_en || code_i != state_q.cfg_code) begin
            state_d.cnt = '0;
        end else if (lvl_i == state_q.acc) begin
            state_d.cnt = '0;
        end else if (tick_i) begin
            if ({1'b0, state_q.cnt} == limit) begin
                state_d.acc = lvl_i;
                state_d.cnt = '0;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign lvl_o = eff_en ? state_q.acc : lvl_i;

    // R11: the accepted level only moves on a tick while filtering
    assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_en && !tick_i) |=> $stable(state_q.acc));

    // R12: an exponent change while filtering restarts the count
    assert_restart_on_cfg_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_en && state_q.cfg_en && code_i != state_q.cfg_code) |=> (state_q.cnt == '0));
endmodule

// File: rtl/pad_trigger.sv
module pad_trigger
    import pad_evt_pkg::*;
#(
    parameter int unsigned DESTS = DEST_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic             gate_i,
    input  trig_mode_e       mode_i,
    input  logic [DESTS-1:0] route_en_i,
    input  logic             clr_i,
    output logic             sts_o,
    output logic [DESTS-1:0] route_o
);
    typedef struct packed {
        logic             prev;
        logic             sts;
        logic [DESTS-1:0] route;
    } trig_state_t;

    trig_state_t state_d, state_q;
    logic rise, fall, evt;

    always_comb begin
        rise = lvl_i & ~state_q.prev;
        fall = ~lvl_i & state_q.prev;
        case (mode_i)
            TRIG_LEVEL:  evt = lvl_i;
            TRIG_SINGLE: evt = rise;
            TRIG_BOTH:   evt = rise | fall;
            default:     evt = 1'b0;
        endcase
        evt = evt & gate_i;

        state_d       = state_q;
        state_d.prev  = lvl_i;
        state_d.sts   = (state_q.sts & ~clr_i) | evt;
        for (int k = 0; k < int'(DESTS); k++) begin
            state_d.route[k] = evt & route_en_i[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sts_o   = state_q.sts;
    assign route_o = state_q.route;

    // R8: each destination pulses only when it was enabled
    for (genvar g = 0; g < int'(DESTS); g++) begin : g_dest_chk
        assert_dest_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
            state_q.route[g] |-> $past(route_en_i[g]));
    end

    // R6: trigger off keeps everything quiet
    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_OFF) |=> (state_q.route == '0 && !$rose(state_q.sts)));

    // R9: status is sticky without a clear
    assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.sts && !clr_i) |=> state_q.sts);

    // R10: receive disabled blocks every event
    assert_gate_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |=> (!$rose(state_q.sts) && state_q.route == '0));

    // R14: single-edge requests last one cycle
    assert_single_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TRIG_SINGLE && state_q.route != '0) |=> (state_q.route == '0));
endmodule

// File: rtl/pad_event_detect.sv
module pad_event_detect
    import pad_evt_pkg::*;
#(
    parameter int unsigned DESTS       = DEST_COUNT,
    parameter int unsigned CODE_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_rx_i,
    input  logic              rtc_tick_i,
    input  logic              rx_disable_i,
    input  logic              rx_invert_i,
    input  logic [1:0]        trig_mode_i,
    input  logic [DESTS-1:0]  route_en_i,
    input  logic              deb_en_i,
    input  logic [CODE_W-1:0] deb_code_i,
    input  logic              status_clr_i,
    output logic              status_o,
    output logic [DESTS-1:0]  route_o
);
    logic pad_sync_lvl;
    logic cond_lvl;
    logic filt_lvl;

    pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_rx_i),
        .sync_o  (pad_sync_lvl)
    );

    assign cond_lvl = ~rx_disable_i & (pad_sync_lvl ^ rx_invert_i);

    pad_debounce #(.CODE_W(CODE_W), .MIN_CODE(3)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (cond_lvl),
        .tick_i (rtc_tick_i),
        .en_i   (deb_en_i),
        .code_i (deb_code_i),
        .lvl_o  (filt_lvl)
    );

    pad_trigger #(.DESTS(DESTS)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (filt_lvl),
        .gate_i     (~rx_disable_i),
        .mode_i     (trig_mode_e'(trig_mode_i)),
        .route_en_i (route_en_i),
        .clr_i      (status_clr_i),
        .sts_o      (status_o),
        .route_o    (route_o)
    );

    // R1: outputs idle in the first cycle after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!status_o && route_o == '0));
endmodule

// File: tb/tb_pad_event_detect.sv
`timescale 1ns/1ps
module tb_pad_event_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_rx_i = 1'b0;
    logic       rtc_tick_i = 1'b0;
    logic       rx_disable_i = 1'b0;
    logic       rx_invert_i = 1'b0;
    logic [1:0] trig_mode_i = 2'd0;
    logic [3:0] route_en_i = 4'd0;
    logic       deb_en_i = 1'b0;
    logic [3:0] deb_code_i = 4'd0;
    logic       status_clr_i = 1'b0;
    logic       status_o;
    logic [3:0] route_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pad_event_detect dut (
        .clk(clk), .rst_n(rst_n), .pad_rx_i(pad_rx_i), .rtc_tick_i(rtc_tick_i),
        .rx_disable_i(rx_disable_i), .rx_invert_i(rx_invert_i),
        .trig_mode_i(trig_mode_i), .route_en_i(route_en_i), .deb_en_i(deb_en_i),
        .deb_code_i(deb_code_i), .status_clr_i(status_clr_i),
        .status_o(status_o), .route_o(route_o)
    );

    // fields: mode[17:16] inv[15] route[14:11] pre[10] post[9] sts[8] r_first[7:4] r_next[3:0]
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 1'b0, 4'b0001, 1'b0, 1'b1, 1'b1, 4'b0001, 4'b0001}, // R2 level
        {2'd0, 1'b1, 4'b0100, 1'b1, 1'b0, 1'b1, 4'b0100, 4'b0100}, // R7 active low
        {2'd1, 1'b0, 4'b0010, 1'b0, 1'b1, 1'b1, 4'b0010, 4'b0000}, // R3 rise
        {2'd1, 1'b0, 4'b0010, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000}, // R3 fall ignored
        {2'd1, 1'b1, 4'b1000, 1'b1, 1'b0, 1'b1, 4'b1000, 4'b0000}, // R4 fall
        {2'd1, 1'b1, 4'b1000, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0000}, // R4 rise ignored
        {2'd3, 1'b0, 4'b0011, 1'b1, 1'b0, 1'b1, 4'b0011, 4'b0000}, // R5 R8
        {2'd3, 1'b0, 4'b1111, 1'b0, 1'b1, 1'b1, 4'b1111, 4'b0000}, // R5 R8 R14
        {2'd2, 1'b0, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0000}, // R6
        {2'd2, 1'b1, 4'b1111, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000}, // R6
        {2'd0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0000, 4'b0000}, // R8 no routes
        {2'd3, 1'b1, 4'b0101, 1'b0, 1'b1, 1'b1, 4'b0101, 4'b0000}  // R5 inverted
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_status();
        status_clr_i = 1'b1;
        step(1);
        status_clr_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int t = 0; t < n; t++) begin
            rtc_tick_i = 1'b1;
            step(1);
            rtc_tick_i = 1'b0;
            step(1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 status after reset", 32'(status_o), 32'd0);
        check("R1 routes after reset", 32'(route_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            trig_mode_i = VEC[i][17:16];
            rx_invert_i = VEC[i][15];
            route_en_i  = VEC[i][14:11];
            pad_rx_i    = VEC[i][10];
            step(6);
            clear_status();
            step(2);
            pad_rx_i = VEC[i][9];
            step(3);
            check($sformatf("vector %0d status", i), 32'(status_o), 32'(VEC[i][8]));
            check($sformatf("vector %0d route first", i), 32'(route_o), 32'(VEC[i][7:4]));
            step(1);
            check($sformatf("vector %0d route next (R14/R2)", i), 32'(route_o), 32'(VEC[i][3:0]));
        end

        // R9 sticky status and clear; R2 route follows level down
        trig_mode_i = 2'd0; rx_invert_i = 1'b0; route_en_i = 4'b0001;
        pad_rx_i = 1'b0; step(6); clear_status();
        pad_rx_i = 1'b1; step(4);
        pad_rx_i = 1'b0; step(6);
        check("R9 status held", 32'(status_o), 32'd1);
        check("R2 route drops with level", 32'(route_o), 32'd0);
        clear_status();
        check("R9 status cleared", 32'(status_o), 32'd0);
        pad_rx_i = 1'b1; step(4);
        clear_status();
        check("R9 set wins over clear", 32'(status_o), 32'd1);

        // R10 receive disable
        pad_rx_i = 1'b0; trig_mode_i = 2'd3; route_en_i = 4'b1111;
        step(4);
        rx_disable_i = 1'b1; step(4); clear_status();
        pad_rx_i = 1'b1; step(3);
        check("R10 route blocked", 32'(route_o), 32'd0);
        step(3);
        pad_rx_i = 1'b0; step(3);
        check("R10 route blocked on fall", 32'(route_o), 32'd0);
        step(3);
        check("R10 status never set", 32'(status_o), 32'd0);
        rx_disable_i = 1'b0;
        step(4);

        // R11 debounce window of 8 ticks
        trig_mode_i = 2'd1; route_en_i = 4'b0001;
        deb_en_i = 1'b1; deb_code_i = 4'd3;
        pad_rx_i = 1'b0; step(6); clear_status();
        pad_rx_i = 1'b1; step(4);
        ticks(7);
        step(2);
        check("R11 not accepted after 7 ticks", 32'(status_o), 32'd0);
        ticks(1);
        step(2);
        check("R11 accepted after 8 ticks", 32'(status_o), 32'd1);

        // R11 short excursion dropped
        trig_mode_i = 2'd3; step(2); clear_status();
        pad_rx_i = 1'b0; step(4);
        ticks(5);
        pad_rx_i = 1'b1; step(4);
        ticks(10);
        step(2);
        check("R11 glitch dropped", 32'(status_o), 32'd0);

        // R12 restart on exponent change
        pad_rx_i = 1'b0; step(4);
        ticks(5);
        deb_code_i = 4'd4;
        step(2);
        ticks(12);
        step(2);
        check("R12 count restarted", 32'(status_o), 32'd0);
        ticks(4);
        step(2);
        check("R12 accepted after 16 ticks", 32'(status_o), 32'd1);

        // R13 exponent below 3 bypasses the filter
        deb_code_i = 4'd2;
        step(4); clear_status();
        pad_rx_i = 1'b1; step(3);
        check("R13 immediate status", 32'(status_o), 32'd1);
        check("R13 immediate route", 32'(route_o), 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule